// File: doc/BRIEF.md
# Serial Audio Frame Deserializer

This block receives the serial frames of a point-to-point audio link and turns them into parallel slot words. A bit clock times every bit, and a frame sync line marks where each frame begins. Up to two data lines carry traffic: one from the controller to the codec and one back from the codec. Each line that is enabled is deserialized on its own, but both share the same slot boundaries. Every line and the sync are sampled on the falling edge of the bit clock.

A frame is 256 bits long. It holds a 16-bit tag slot followed by twelve slots of 20 bits each. Each slot arrives most significant bit first. When the last bit of a slot has been captured, the block raises a one-cycle strobe for each enabled direction. It presents the slot index and the slot value along with the strobe, and for the audio slots it also presents a 16-bit audio word. The bit position of the strobe is the direction flag. The surrounding logic reads the slot words from these ports and does its own field interpretation.

Top module: `frame_deser`

## Requirements
- R1: The sync line and both data lines are sampled only on falling edges of the bit clock.
- R2: A frame starts when the sync sample taken at one falling edge is high and the sync sample taken at the falling edge before it is low. The data bit sampled at the next falling edge is frame bit 0. While sync stays high, no new frame starts.
- R3: Slot 0 covers frame bits 0 to 15. Slot k, for k from 1 to 12, covers bits 16+20*(k-1) to 35+20*(k-1). A strobe marks the completion of each slot, and the slot index output holds k.
- R4: Slot values are assembled MSB first: the first bit received in a slot is its most significant bit. The 16-bit value of slot 0 is placed in bits 15:0 of the value output, and bits 19:16 read zero.
- R5: Bits received after frame bit 255, up to the next frame start, produce no strobe and do not change the outputs.
- R6: The strobe output has two bits. Bit 0 belongs to the controller-to-codec line and bit 1 to the codec-to-controller line. Each direction is enabled by its own parameter. A disabled direction never strobes and its outputs stay zero. When both directions are enabled, they strobe in the same cycle with their own values.
- R7: For slots 3 to 12, the audio word equals bits 19:4 of the slot value. For slots 0 to 2, the audio word is zero.
- R8: After reset, no strobe occurs until the first frame start.
- R9: A strobe lasts one bit-clock cycle: the cycle that follows the falling edge at which the last bit of the slot is captured. The slot index, values and audio words stay unchanged until the next strobe.
- R10: A frame start that arrives in the middle of a frame restarts the count at bit 0 and slot 0. The partly received slot is dropped without a strobe.
- R11: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock; all state updates on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| syncIn | input | 1 | Frame sync line |
| txData | input | 1 | Controller-to-codec serial data |
| rxData | input | 1 | Codec-to-controller serial data |
| slotStb | output | 2 | Per-direction slot-complete strobe (bit 0 controller-to-codec, bit 1 codec-to-controller) |
| slotIdx | output | 4 | Index of the most recently completed slot |
| txSlotVal | output | 20 | Controller-to-codec slot value |
| rxSlotVal | output | 20 | Codec-to-controller slot value |
| txAudio | output | 16 | Controller-to-codec audio word |
| rxAudio | output | 16 | Codec-to-controller audio word |

## Verification
A new frame start and the completion of a slot can land on the same falling edge. This happens, for example, when a frame is cut short and the restart edge falls where a slot boundary would have been. The two enabled directions also complete their slots in the same cycle. The bench provokes restarts by cutting frames at several points and then sending a full frame. It judges the outcome by the index sequence, which must begin again at slot 0, and by exact slot values computed from the bits it sent. Every strobe is checked on both directions at once. A second instance with only one direction enabled confirms that the missing direction stays silent.

// File: rtl/frame_slot_pkg.sv
package frame_slot_pkg;
  localparam int SLOT0_W     = 16;
  localparam int SLOT_W      = 20;
  localparam int SLOT_CNT    = 13;
  localparam int FRAME_W     = SLOT0_W + SLOT_W * (SLOT_CNT - 1);
  localparam int IDX_W       = $clog2(SLOT_CNT);
  localparam int POS_W       = $clog2(FRAME_W);
  localparam int AUDIO_W     = 16;
  localparam int AUDIO_LSB   = SLOT_W - AUDIO_W;
  localparam int AUDIO_FIRST = 3;

  typedef struct packed {
    logic             bitValid;
    logic             slotEnd;
    logic [IDX_W-1:0] slotIdx;
  } ctrlStb_t;
endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import frame_slot_pkg::*;
(
  input  logic             bitClk,
  input  logic             rstN,
  input  logic             syncIn,
  output ctrlStb_t         stb,
  output logic [IDX_W-1:0] idxOut
);
  logic             syncQ1, syncQ2, active, startNow;
  logic [POS_W-1:0] bitCnt, curPos;
  logic [IDX_W-1:0] slotCnt, curSlot;
  int               lastPos;

  assign startNow = syncQ1 & ~syncQ2;
  assign curPos   = startNow ? '0 : bitCnt;
  assign curSlot  = startNow ? '0 : slotCnt;

  always_comb begin
    lastPos      = SLOT0_W - 1 + SLOT_W * int'(curSlot);
    stb.bitValid = startNow | active;
    stb.slotEnd  = stb.bitValid && (int'(curPos) == lastPos);
    stb.slotIdx  = curSlot;
  end

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      syncQ1  <= 1'b0;
      syncQ2  <= 1'b0;
      active  <= 1'b0;
      bitCnt  <= '0;
      slotCnt <= '0;
      idxOut  <= '0;
    end else begin
      syncQ2 <= syncQ1;
      syncQ1 <= syncIn;
      if (stb.bitValid) begin
        active  <= (curPos != POS_W'(FRAME_W - 1));
        bitCnt  <= curPos + 1'b1;
        slotCnt <= stb.slotEnd ? curSlot + 1'b1 : curSlot;
      end
      if (stb.slotEnd) idxOut <= curSlot;
    end
  end

  // checker-only state: has any frame start been seen since reset
  logic gotSync;
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) gotSync <= 1'b0;
    else if (startNow) gotSync <= 1'b1;
  end

  assert_quiet_before_sync_R8: assert property (@(negedge bitClk) disable iff (!rstN)
    !gotSync && !startNow |-> !stb.slotEnd);
  assert_slot_gap_R3: assert property (@(negedge bitClk) disable iff (!rstN)
    stb.slotEnd |=> !stb.slotEnd);
  assert_last_slot_ends_frame_R5: assert property (@(negedge bitClk) disable iff (!rstN)
    stb.slotEnd && stb.slotIdx == IDX_W'(SLOT_CNT - 1) |=> !active);
endmodule

// File: rtl/slot_lane.sv
module slot_lane
  import frame_slot_pkg::*;
(
  input  logic               bitClk,
  input  logic               rstN,
  input  logic               dataIn,
  input  ctrlStb_t           stb,
  output logic               laneStb,
  output logic [SLOT_W-1:0]  laneVal,
  output logic [AUDIO_W-1:0] laneAudio
);
  logic [SLOT_W-2:0] shiftReg;
  logic [SLOT_W-1:0] nextWord;

  assign nextWord = {shiftReg, dataIn};

  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      laneStb   <= 1'b0;
      laneVal   <= '0;
      laneAudio <= '0;
    end else begin
      laneStb <= stb.slotEnd;
      if (stb.bitValid) shiftReg <= nextWord[SLOT_W-2:0];
      if (stb.slotEnd) begin
        if (stb.slotIdx == '0)
          laneVal <= {{(SLOT_W - SLOT0_W){1'b0}}, nextWord[SLOT0_W-1:0]};
        else
          laneVal <= nextWord;
        laneAudio <= (stb.slotIdx >= IDX_W'(AUDIO_FIRST)) ?
                     nextWord[SLOT_W-1:AUDIO_LSB] : '0;
      end
    end
  end

  assert_strobe_pulse_R9: assert property (@(negedge bitClk) disable iff (!rstN)
    laneStb |=> !laneStb);
  assert_value_hold_R9: assert property (@(negedge bitClk) disable iff (!rstN)
    !laneStb |-> $stable(laneVal) && $stable(laneAudio));
endmodule

// File: rtl/frame_deser.sv
module frame_deser
  import frame_slot_pkg::*;
#(
  parameter bit ENABLE_TX = 1'b1,
  parameter bit ENABLE_RX = 1'b1
) (
  input  logic               bitClk,
  input  logic               rstN,
  input  logic               syncIn,
  input  logic               txData,
  input  logic               rxData,
  output logic [1:0]         slotStb,
  output logic [IDX_W-1:0]   slotIdx,
  output logic [SLOT_W-1:0]  txSlotVal,
  output logic [SLOT_W-1:0]  rxSlotVal,
  output logic [AUDIO_W-1:0] txAudio,
  output logic [AUDIO_W-1:0] rxAudio
);
  localparam logic [1:0] LANE_EN = {ENABLE_RX, ENABLE_TX};

  ctrlStb_t          ctrlStb;
  logic [1:0]        dataVec;
  logic [SLOT_W-1:0]  laneVal   [2];
  logic [AUDIO_W-1:0] laneAudio [2];

  initial assert_one_lane_R6: assert (LANE_EN != 2'b00);

  assign dataVec = {rxData, txData};

  slot_ctrl uCtrl (
    .bitClk (bitClk),
    .rstN   (rstN),
    .syncIn (syncIn),
    .stb    (ctrlStb),
    .idxOut (slotIdx)
  );

  for (genvar d = 0; d < 2; d++) begin : gLane
    if (LANE_EN[d]) begin : gOn
      slot_lane uLane (
        .bitClk    (bitClk),
        .rstN      (rstN),
        .dataIn    (dataVec[d]),
        .stb       (ctrlStb),
        .laneStb   (slotStb[d]),
        .laneVal   (laneVal[d]),
        .laneAudio (laneAudio[d])
      );
    end else begin : gOff
      assign slotStb[d]   = 1'b0;
      assign laneVal[d]   = '0;
      assign laneAudio[d] = '0;
    end
  end

  assign txSlotVal = laneVal[0];
  assign rxSlotVal = laneVal[1];
  assign txAudio   = laneAudio[0];
  assign rxAudio   = laneAudio[1];

  if (ENABLE_TX && ENABLE_RX) begin : gBoth
    assert_dirs_aligned_R6: assert property (@(negedge bitClk) disable iff (!rstN)
      slotStb[0] == slotStb[1]);
  end
endmodule

// File: tb/sim_frame_deser.sv
module sim_frame_deser;
  localparam int BCLK_PERIOD = 10;

  logic bitClk = 1'b0;
  logic rstN, syncIn, txData, rxData;
  logic [1:0]  slotStb, oneStb;
  logic [3:0]  slotIdx, oneIdx;
  logic [19:0] txSlotVal, rxSlotVal, oneTx, oneRx;
  logic [15:0] txAudio, rxAudio, oneTxA, oneRxA;

  always #(BCLK_PERIOD / 2) bitClk = ~bitClk;

  frame_deser u0 (
    .bitClk(bitClk), .rstN(rstN), .syncIn(syncIn), .txData(txData), .rxData(rxData),
    .slotStb(slotStb), .slotIdx(slotIdx), .txSlotVal(txSlotVal), .rxSlotVal(rxSlotVal),
    .txAudio(txAudio), .rxAudio(rxAudio));

  frame_deser #(.ENABLE_TX(1'b1), .ENABLE_RX(1'b0)) u1 (
    .bitClk(bitClk), .rstN(rstN), .syncIn(syncIn), .txData(txData), .rxData(rxData),
    .slotStb(oneStb), .slotIdx(oneIdx), .txSlotVal(oneTx), .rxSlotVal(oneRx),
    .txAudio(oneTxA), .rxAudio(oneRxA));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0]  lastIdx;
  logic [19:0] lastTx, lastRx;

  function automatic int slotLen(int k);
    return (k == 0) ? 16 : 20;
  endfunction

  function automatic int slotFirst(int k);
    return (k == 0) ? 0 : 16 + 20 * (k - 1);
  endfunction

  function automatic logic [15:0] expAudio(int k, logic [19:0] v);
    return (k >= 3) ? v[19:4] : 16'h0;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // inputs change on the rising edge; the design samples on the falling edge (R1)
  task automatic stepBit(bit s, bit t, bit r);
    @(posedge bitClk);
    syncIn = s; txData = t; rxData = r;
    @(negedge bitClk);
    #1;
  endtask

  // a non-strobe cycle must show no strobe and unchanged outputs
  function automatic bit quietOk();
    return slotStb == 2'b00 && oneStb == 2'b00 && slotIdx == lastIdx &&
           txSlotVal == lastTx && rxSlotVal == lastRx && oneTx == lastTx;
  endfunction

  task automatic quietBits(int n, string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      stepBit(1'b0, 1'($urandom), 1'($urandom));
      if (!quietOk()) bad++;
    end
    check(bad == 0, req, "quiet cycles with strobe or output change", bad, 0);
  endtask

  task automatic sendFrame(int syncHi, int cutAt, string req);
    logic [19:0] txS [13];
    logic [19:0] rxS [13];
    int bad = 0;
    for (int k = 0; k < 13; k++) begin
      txS[k] = 20'($urandom);
      rxS[k] = 20'($urandom);
      if (k == 0) begin
        txS[k][19:16] = 4'h0;
        rxS[k][19:16] = 4'h0;
      end
    end
    // a low sync sample, then the high sample one bit ahead of bit 0 (R2)
    stepBit(1'b0, 1'($urandom), 1'($urandom));
    if (!quietOk()) bad++;
    stepBit(1'b1, 1'($urandom), 1'($urandom));
    if (!quietOk()) bad++;
    for (int i = 0; i < cutAt; i++) begin
      int k = 0;
      int j;
      for (int m = 1; m < 13; m++) if (i >= slotFirst(m)) k = m;
      j = i - slotFirst(k);
      stepBit(i < syncHi, txS[k][slotLen(k) - 1 - j], rxS[k][slotLen(k) - 1 - j]);
      if (j == slotLen(k) - 1) begin
        check(slotStb == 2'b11, req, "R3 strobe at slot end", slotStb, 2'b11);
        check(slotIdx == 4'(k), req, "R3 slot index", slotIdx, k);
        check(txSlotVal == txS[k], req, "R4 tx slot value MSB first", txSlotVal, txS[k]);
        check(rxSlotVal == rxS[k], req, "R6 rx slot value", rxSlotVal, rxS[k]);
        check(txAudio == expAudio(k, txS[k]) && rxAudio == expAudio(k, rxS[k]), req,
              "R7 audio word", {txAudio, rxAudio}, {expAudio(k, txS[k]), expAudio(k, rxS[k])});
        check(oneStb == 2'b01 && oneTx == txS[k] && oneRx == 20'h0 && oneRxA == 16'h0,
              "R6", "single-direction instance", {oneStb, oneRx[13:0]}, {2'b01, 14'h0});
        lastIdx = 4'(k); lastTx = txS[k]; lastRx = rxS[k];
      end else if (!quietOk()) bad++;
    end
    check(bad == 0, "R9", "strobe or output change between slot ends", bad, 0);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rstN = 1'b0; syncIn = 1'b0; txData = 1'b0; rxData = 1'b0;
    repeat (3) @(posedge bitClk);
    #1;
    check(slotStb == 0 && slotIdx == 0 && txSlotVal == 0 && rxSlotVal == 0 &&
          txAudio == 0 && rxAudio == 0, "R11", "outputs in reset", slotStb, 0);
    @(posedge bitClk);
    rstN = 1'b1;
    lastIdx = 4'h0; lastTx = 20'h0; lastRx = 20'h0;
    quietBits(60, "R8");
    sendFrame(16, 256, "R3");
    quietBits(30, "R5");
    sendFrame(1, 256, "R2");
    sendFrame(200, 256, "R2");
    sendFrame(0, 256, "R4");
    sendFrame(16, 45, "R10");
    sendFrame(16, 256, "R10");
    sendFrame(16, 8, "R10");
    sendFrame(3, 100, "R10");
    sendFrame(16, 256, "R10");
    for (int n = 0; n < 10; n++) begin
      sendFrame($urandom_range(0, 40), 256, "R3");
      if (n % 3 == 0) quietBits($urandom_range(1, 20), "R5");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(BCLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before the end of stimulus");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule